// File: doc/BRIEF.md
# Instrument Status Summary Hierarchy

This block gathers instrument status into a layered summary. Three status groups exist: operation, questionable and standard-event. Each group keeps a condition register that samples a live condition vector. It also keeps a sticky event register that latches only on rising conditions, and a software-written enable mask. For each group, the events that pass its mask reduce to a single summary bit. These summary bits, a message-available flag and a derived service-request bit together form an 8-bit status byte. The service-request bit is also driven on a dedicated output.

Software reaches the block through a simple register port with separate, single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe. Reading an event register returns it and clears it in the same access. The questionable group carries no condition sources: its registers can still be addressed, and its event register always reads zero. A preset input returns every event register and every mask to zero in a single cycle.

Top module: `stat_hier`

## Requirements
- R1: After reset, every event register, enable mask and the service-request enable read 0, and `status_byte`, `srq` and `rd_data` are 0.
- R2: A condition bit sampled at 1 at a clock edge, when it was sampled at 0 at the previous edge (or reset), sets the matching event bit at that edge. A condition held at 1, or falling to 0, sets nothing.
- R3: An event bit stays at 1 after its condition returns to 0, until it is read or preset.
- R4: A read strobe at an event address returns the event register in `rd_data` on the following cycle and clears that register at the same edge.
- R5: A rising transition in the same cycle as a read of its event register leaves that bit set after the read, and the bit is absent from the returned data.
- R6: `status_byte` is registered from the current registers one cycle later. Bit 7 is OR(operation events AND mask), bit 5 is OR(standard events AND mask), bit 3 is the same for the questionable group, bit 4 is `msg_avail`, and bits 2..0 are 0.
- R7: The questionable group's condition and event registers always read 0, its summary bit 3 stays 0, and its enable mask is still readable and writable.
- R8: `status_byte[6]` is 1 when any other status-byte bit ANDed with the 8-bit service-request enable is 1. Enable bit 6 has no effect, and `srq` equals `status_byte[6]`.
- R9: Address map (`addr[3:2]` picks the group: 0 operation, 1 questionable, 2 standard-event; then `addr[1:0]`: 0 condition, 1 event, 2 enable). Address 12 reads the status byte and address 13 reads or writes the service-request enable in bits 7..0. Enables read back as written, and unused addresses read 0.
- R10: A one-cycle `preset` clears all event registers, group enable masks and the service-request enable. A rising transition in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preset | input | 1 | Clears events and all enable masks |
| oper_cond | input | W | Operation group condition vector |
| std_cond | input | W | Standard-event group condition vector |
| msg_avail | input | 1 | Message-available flag, status byte bit 4 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | W | Registered read data |
| status_byte | output | 8 | Registered status byte |
| srq | output | 1 | Service-request output |

## Verification
On every cycle, the assertions check four things: that a rising condition sets its event bit, that event bits stay sticky until cleared, that a read clears an event register apart from bits rising in that same cycle, and that the questionable events stay zero. They also check that the operation summary and the service-request bit track their registered sources one cycle later, and that preset empties everything. The bench scenarios are needed for the rest: the per-bit transition sweep that shows levels and falling edges setting nothing, the returned read data and the address map, the same-cycle read and rise case, and the sweep of every service-request enable value against eight status-byte states.

// File: rtl/stat_hier_pkg.sv
package stat_hier_pkg;
  localparam int NUM_GRP  = 3;
  localparam int GRP_OPER = 0;
  localparam int GRP_QUES = 1;
  localparam int GRP_STD  = 2;
  localparam int ADDR_W   = 4;
  localparam int SB_W     = 8;
  localparam int STB_OPER = 7;
  localparam int STB_RQS  = 6;
  localparam int STB_ESB  = 5;
  localparam int STB_MAV  = 4;
  localparam int STB_QUES = 3;

  typedef enum logic [1:0] {
    SEL_COND = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [1:0] MISC_GRP = 2'd3;
  localparam logic [1:0] MISC_STB = 2'd0;
  localparam logic [1:0] MISC_SRE = 2'd1;
endpackage

// File: rtl/stat_group.sv
module stat_group #(
  parameter int W        = 16,
  parameter bit HAS_COND = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset,
  input  logic [W-1:0] cond_in,
  input  logic         evt_clr,
  input  logic         en_we,
  input  logic [W-1:0] en_wd,
  output logic [W-1:0] cond_q,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] en_q,
  output logic         summary
);
  logic [W-1:0] rise;

  generate
    if (HAS_COND) begin : g_cond
      always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= cond_in;
      end
    end else begin : g_nocond
      assign cond_q = '0;
    end
  endgenerate

  // positive transition filter
  assign rise = cond_in & ~cond_q & {W{HAS_COND}};

  always_ff @(posedge clk) begin
    if (rst || preset) begin
      evt_q <= '0;
    end else begin
      evt_q <= (evt_clr ? '0 : evt_q) | rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || preset) en_q <= '0;
    else if (en_we)    en_q <= en_wd;
  end

  assign summary = |(evt_q & en_q);
endmodule

// File: rtl/stat_stb_build.sv
module stat_stb_build
  import stat_hier_pkg::*;
#(
  parameter int NG = NUM_GRP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            preset,
  input  logic [NG-1:0]   grp_sum,
  input  logic            mav,
  input  logic            sre_we,
  input  logic [SB_W-1:0] sre_wd,
  output logic [SB_W-1:0] sre_q,
  output logic [SB_W-1:0] stb_q,
  output logic            srq
);
  localparam logic [SB_W-1:0] RQS_MASK = ~(SB_W'(1) << STB_RQS);

  logic [SB_W-1:0] stb_c;
  logic            rqs_c;

  always_comb begin
    stb_c           = '0;
    stb_c[STB_OPER] = grp_sum[GRP_OPER];
    stb_c[STB_ESB]  = grp_sum[GRP_STD];
    stb_c[STB_QUES] = grp_sum[GRP_QUES];
    stb_c[STB_MAV]  = mav;
    rqs_c           = |(stb_c & sre_q & RQS_MASK);
    stb_c[STB_RQS]  = rqs_c;
  end

  always_ff @(posedge clk) begin
    if (rst || preset) sre_q <= '0;
    else if (sre_we)   sre_q <= sre_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= '0;
      srq   <= 1'b0;
    end else begin
      stb_q <= stb_c;
      srq   <= rqs_c;
    end
  end
endmodule

// File: rtl/stat_rd_mux.sv
module stat_rd_mux
  import stat_hier_pkg::*;
#(
  parameter int W  = 16,
  parameter int NG = NUM_GRP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NG-1:0][W-1:0]   cond_v,
  input  logic [NG-1:0][W-1:0]   evt_v,
  input  logic [NG-1:0][W-1:0]   en_v,
  input  logic [SB_W-1:0]        stb,
  input  logic [SB_W-1:0]        sre,
  output logic [W-1:0]           rd_data
);
  logic [1:0]   grp;
  reg_sel_e     sel;
  logic [W-1:0] grp_word;
  logic [W-1:0] mux_c;

  assign grp = rd_addr[3:2];
  assign sel = reg_sel_e'(rd_addr[1:0]);

  always_comb begin
    grp_word = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp == 2'(g)) begin
        case (sel)
          SEL_COND: grp_word = cond_v[g];
          SEL_EVT:  grp_word = evt_v[g];
          SEL_EN:   grp_word = en_v[g];
          default:  grp_word = '0;
        endcase
      end
    end
  end

  always_comb begin
    mux_c = grp_word;
    if (grp == MISC_GRP) begin
      if (rd_addr[1:0] == MISC_STB)      mux_c = W'(stb);
      else if (rd_addr[1:0] == MISC_SRE) mux_c = W'(sre);
      else                               mux_c = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mux_c;
  end
endmodule

// File: rtl/stat_hier.sv
module stat_hier
  import stat_hier_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset,
  input  logic [W-1:0]      oper_cond,
  input  logic [W-1:0]      std_cond,
  input  logic              msg_avail,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic [SB_W-1:0]   status_byte,
  output logic              srq
);
  logic [NUM_GRP-1:0][W-1:0] grp_condq;
  logic [NUM_GRP-1:0][W-1:0] grp_evt;
  logic [NUM_GRP-1:0][W-1:0] grp_en;
  logic [NUM_GRP-1:0]        grp_sum;
  logic [NUM_GRP-1:0]        evt_clr;
  logic [NUM_GRP-1:0]        en_we;
  logic [SB_W-1:0]           sre_q;
  logic                      sre_we;

  assign sre_we = wr_en && wr_addr[3:2] == MISC_GRP && wr_addr[1:0] == MISC_SRE;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [W-1:0] cin;
      if (g == GRP_OPER) begin : g_op
        assign cin = oper_cond;
      end else if (g == GRP_STD) begin : g_sd
        assign cin = std_cond;
      end else begin : g_none
        assign cin = '0;
      end

      assign evt_clr[g] = rd_en && rd_addr[3:2] == 2'(g) && rd_addr[1:0] == SEL_EVT;
      assign en_we[g]   = wr_en && wr_addr[3:2] == 2'(g) && wr_addr[1:0] == SEL_EN;

      stat_group #(
        .W        (W),
        .HAS_COND (g != GRP_QUES)
      ) u_grp (
        .clk     (clk),
        .rst     (rst),
        .preset  (preset),
        .cond_in (cin),
        .evt_clr (evt_clr[g]),
        .en_we   (en_we[g]),
        .en_wd   (wr_data),
        .cond_q  (grp_condq[g]),
        .evt_q   (grp_evt[g]),
        .en_q    (grp_en[g]),
        .summary (grp_sum[g])
      );
    end
  endgenerate

  stat_stb_build #(.NG(NUM_GRP)) u_stb (
    .clk     (clk),
    .rst     (rst),
    .preset  (preset),
    .grp_sum (grp_sum),
    .mav     (msg_avail),
    .sre_we  (sre_we),
    .sre_wd  (wr_data[SB_W-1:0]),
    .sre_q   (sre_q),
    .stb_q   (status_byte),
    .srq     (srq)
  );

  stat_rd_mux #(.W(W), .NG(NUM_GRP)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cond_v  (grp_condq),
    .evt_v   (grp_evt),
    .en_v    (grp_en),
    .stb     (status_byte),
    .sre     (sre_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/stat_hier_chk.sv
module stat_hier_chk
  import stat_hier_pkg::*;
#(
  parameter int W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      preset,
  input logic [W-1:0]              oper_cond,
  input logic [W-1:0]              std_cond,
  input logic [NUM_GRP-1:0][W-1:0] g_condq,
  input logic [NUM_GRP-1:0][W-1:0] g_evt,
  input logic [NUM_GRP-1:0][W-1:0] g_en,
  input logic [NUM_GRP-1:0]        evt_clr,
  input logic [SB_W-1:0]           sre,
  input logic [SB_W-1:0]           status_byte,
  input logic                      srq
);
  // R2
  rise_sets_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset && (oper_cond & ~g_condq[GRP_OPER]) != '0) |=>
      ((g_evt[GRP_OPER] & $past(oper_cond & ~g_condq[GRP_OPER])) ==
        $past(oper_cond & ~g_condq[GRP_OPER])));

  // R3
  evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset && !evt_clr[GRP_OPER]) |=>
      ((g_evt[GRP_OPER] & $past(g_evt[GRP_OPER])) == $past(g_evt[GRP_OPER])));

  // R4 R5
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_clr[GRP_STD] && !preset) |=>
      (g_evt[GRP_STD] == $past(std_cond & ~g_condq[GRP_STD])));

  // R7
  ques_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (g_evt[GRP_QUES] == '0 && !status_byte[STB_QUES]));

  // R6
  oper_summary_chk: assert property (@(posedge clk) disable iff (rst)
    !preset |=> (status_byte[STB_OPER] == $past(|(g_evt[GRP_OPER] & g_en[GRP_OPER]))));

  // R8
  srq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !preset |=> (srq == |(status_byte & 8'hBF & $past(sre)) && srq == status_byte[STB_RQS]));

  // R10
  preset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    preset |=> (g_evt == '0 && g_en == '0 && sre == '0));
endmodule

bind stat_hier stat_hier_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .preset      (preset),
  .oper_cond   (oper_cond),
  .std_cond    (std_cond),
  .g_condq     (grp_condq),
  .g_evt       (grp_evt),
  .g_en        (grp_en),
  .evt_clr     (evt_clr),
  .sre         (sre_q),
  .status_byte (status_byte),
  .srq         (srq)
);

// File: tb/stat_hier_tb.sv
module stat_hier_tb;
  localparam int W = 16;
  localparam logic [3:0] A_OP_COND = 4'd0, A_OP_EVT = 4'd1, A_OP_EN = 4'd2;
  localparam logic [3:0] A_Q_COND = 4'd4, A_Q_EVT = 4'd5, A_Q_EN = 4'd6;
  localparam logic [3:0] A_SE_COND = 4'd8, A_SE_EVT = 4'd9, A_SE_EN = 4'd10;
  localparam logic [3:0] A_STB = 4'd12, A_SRE = 4'd13, A_GAP = 4'd3;

  logic clk = 0, rst = 1, preset = 0, msg_avail = 0;
  logic [W-1:0] oper_cond = '0, std_cond = '0, wr_data = '0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [7:0] status_byte;
  logic srq;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  stat_hier #(.W(W)) u_dut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    rd_en = 1; rd_addr = a; tick(); d = rd_data; rd_en = 0;
  endtask

  task automatic set_cond(input bit std, input logic [W-1:0] v);
    if (std) std_cond = v; else oper_cond = v;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    logic [7:0] e;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 status_byte", W'(status_byte), '0);
    chk("R1 srq", W'(srq), '0);
    chk("R1 rd_data", rd_data, '0);
    rd(A_OP_EN, d);  chk("R1 op enable", d, '0);
    rd(A_SE_EN, d);  chk("R1 se enable", d, '0);
    rd(A_SRE, d);    chk("R1 sre", d, '0);
    rd(A_OP_EVT, d); chk("R1 op event", d, '0);

    // R2 R3 R4 per-bit transition sweep for both driven groups
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < W; b++) begin
        logic [3:0] ae;
        logic [W-1:0] m;
        ae = s ? A_SE_EVT : A_OP_EVT;
        m = W'(1) << b;
        set_cond(s[0], m); tick();
        rd(s ? A_SE_COND : A_OP_COND, d); chk("R9 condition readback", d, m);
        set_cond(s[0], '0); tick();
        rd(ae, d); chk("R3 sticky after fall", d, m);
        rd(ae, d); chk("R4 cleared by read", d, '0);
        set_cond(s[0], m); tick();
        rd(ae, d); chk("R2 rise sets", d, m);
        tick();
        rd(ae, d); chk("R2 held level sets nothing", d, '0);
        set_cond(s[0], '0); tick();
        rd(ae, d); chk("R2 fall sets nothing", d, '0);
      end
    end

    // R5 read in the same cycle as a new rise
    oper_cond = 16'h0001; tick();
    oper_cond = 16'h0003; rd_en = 1; rd_addr = A_OP_EVT; tick(); rd_en = 0;
    chk("R5 returned data", rd_data, 16'h0001);
    rd(A_OP_EVT, d); chk("R5 same-cycle rise kept", d, 16'h0002);
    oper_cond = '0; tick();

    // R9 enable readback and address map
    wr(A_OP_EN, 16'h5A3C); rd(A_OP_EN, d); chk("R9 op enable", d, 16'h5A3C);
    wr(A_SE_EN, 16'hC3A5); rd(A_SE_EN, d); chk("R9 se enable", d, 16'hC3A5);
    wr(A_SRE, 16'hFFFF);   rd(A_SRE, d);   chk("R9 sre 8 bits", d, 16'h00FF);
    rd(A_GAP, d); chk("R9 unused address", d, '0);
    wr(A_SRE, '0);

    // R6 summary per enable bit
    oper_cond = 16'hA5A5; std_cond = 16'h003C; tick();
    oper_cond = '0; std_cond = '0; tick();
    for (int b = 0; b < W; b++) begin
      wr(A_OP_EN, W'(1) << b);
      wr(A_SE_EN, W'(1) << b);
      tick();
      chk("R6 bit7 operation summary", W'(status_byte[7]), W'(16'hA5A5 >> b) & 16'h1);
      chk("R6 bit5 event summary", W'(status_byte[5]), W'(16'h003C >> b) & 16'h1);
      chk("R6 bits 3..0", W'(status_byte[3:0]), '0);
    end
    rd(A_STB, d); chk("R9 status byte read", d, W'(status_byte));

    // R7 questionable group
    wr(A_Q_EN, 16'hFFFF); rd(A_Q_EN, d); chk("R7 ques enable rw", d, 16'hFFFF);
    oper_cond = 16'hFFFF; std_cond = 16'hFFFF; tick();
    rd(A_Q_EVT, d);  chk("R7 ques event", d, '0);
    rd(A_Q_COND, d); chk("R7 ques condition", d, '0);
    chk("R7 ques summary", W'(status_byte[3]), '0);
    oper_cond = '0; std_cond = '0;
    rd(A_OP_EVT, d); rd(A_SE_EVT, d); tick();
    oper_cond = 16'hA5A5; std_cond = 16'h003C; tick();
    oper_cond = '0; std_cond = '0; tick();

    // R6 message available
    msg_avail = 1; tick();
    chk("R6 bit4 msg_avail", W'(status_byte[4]), 16'h1);

    // R8 every service-request enable value over eight status states
    for (int st = 0; st < 8; st++) begin
      wr(A_OP_EN, st[0] ? 16'hFFFF : 16'h0000);
      wr(A_SE_EN, st[1] ? 16'hFFFF : 16'h0000);
      msg_avail = st[2];
      e = {st[0], 1'b0, st[1], st[2], 4'b0000};
      for (int v = 0; v < 256; v++) begin
        logic x;
        wr(A_SRE, W'(v));
        tick();
        x = |(e & 8'(v) & 8'hBF);
        chk("R8 srq", W'(srq), W'(x));
        chk("R8 status byte bit6", W'(status_byte), W'(e | {1'b0, x, 6'b0}));
      end
    end

    // R10 preset, with a rise in the same cycle
    wr(A_OP_EN, 16'h00FF); wr(A_SRE, 16'h00FF);
    msg_avail = 1;
    preset = 1; oper_cond = 16'h0100; tick(); preset = 0;
    rd(A_OP_EN, d);  chk("R10 op enable", d, '0);
    rd(A_OP_EVT, d); chk("R10 op event incl same-cycle rise", d, '0);
    rd(A_SE_EVT, d); chk("R10 se event", d, '0);
    rd(A_SRE, d);    chk("R10 sre", d, '0);
    tick();
    chk("R10 status byte", W'(status_byte), 16'h0010);
    oper_cond = '0;
    finish_run();
  end
endmodule